// File: doc/BRIEF.md
# Pulse-Swallow Feedback Divider Control

This block is the digital control for the feedback divider of an integer-N synthesizer that uses an external two-modulus prescaler. It is clocked by the prescaler output, one edge per prescaler cycle. It drives the prescaler's modulus line: high selects P+1 and low selects P. Over each output period, a down-counter of length B and a swallow counter of length A work together. The modulus line stays high for the first A prescaler cycles and low for the remaining B−A cycles. The feedback path therefore divides the oscillator by N = P·B + A. At the end of every period the block emits a single-cycle pulse for the phase detector.

The divide setting has three parts: B, A and a modulus selector. The block samples them only at the end of a period, or while the hold input is high. Each sampled setting is checked against the range rules. A setting that breaks any rule is rejected: the divider keeps the last accepted setting and raises a sticky error flag. The block has no data stream, so there is no valid/ready handshake. Every pin is a plain control or status level, sampled on the prescaler clock.

Top module: `pss_divider`

## Requirements
- R1: While rst_n is low, div_out is 0, mod_ctl is 0 and cfg_err is 0. The default setting (B=16, A=0, P=8) is in effect when reset ends.
- R2: With hold low, div_out is high for exactly one clock in every B clocks, where B is the accepted length of the current period.
- R3: In each period, mod_ctl is high on the first A clocks after the clock on which div_out was high, and low on the other B−A clocks. The prescaler division over one period is therefore P·B + A.
- R4: The modulus selector cfg_psel uses the encoding 0 → P=8, 1 → P=16, 2 → P=32. The code 3 is illegal.
- R5: cfg_b, cfg_a and cfg_psel are sampled only at the clock edge on which div_out is high, or on an edge with hold high. Changes at other times do not affect the period in progress.
- R6: A sampled setting is rejected if any of these holds: B < 3, cfg_psel = 3, A > P−1, or A > B. On a rejected setting cfg_err goes high on that edge and the previously accepted B and A stay in use.
- R7: While hold is high, div_out and mod_ctl are low and both counters are reloaded from the sampled setting every clock. Once hold falls, the first period lasts a full B clocks.
- R8: A=0 keeps mod_ctl low for the whole period. A=B keeps mod_ctl high for the whole period.
- R9: Once set, cfg_err stays high through later legal settings, and only rst_n clears it. Legal settings are still accepted while cfg_err is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Prescaler output clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| hold | input | 1 | Synchronous hold: counters sit at start, outputs low |
| cfg_b | input | 13 | Requested main count B |
| cfg_a | input | 5 | Requested swallow count A |
| cfg_psel | input | 2 | Modulus selector (0:8, 1:16, 2:32) |
| mod_ctl | output | 1 | Prescaler modulus select, 1 = P+1 |
| div_out | output | 1 | One-clock pulse per N-cycle period |
| cfg_err | output | 1 | Sticky illegal-setting flag |

## Verification
Some properties are checked by assertions on every clock:
- the output pulse is never two clocks wide;
- once the modulus line falls within a period, it stays low until the next reload;
- the error flag is sticky;
- a period cannot end on the clock after hold;
- the setting held in the block always meets the B and A range rules.

Other behaviour only the bench scenarios can show. These are the exact period length, the exact number of P+1 cycles for each modulus selection, the point at which a mid-period change takes effect, and the fact that a rejected setting leaves the previous division in force. The bench shows them by comparing both outputs and the flag against a behavioural position-in-period model on every clock.

// File: rtl/pss_pkg.sv
package pss_pkg;
  // Number of legal prescaler sizes and log2 of the smallest one.
  localparam int NUM_MOD = 3;
  localparam int MIN_MOD_LOG2 = 3;
  localparam int B_LEGAL_MIN = 3;

  // Largest legal swallow count for selector code i (P-1).
  function automatic int swallow_limit(input int i);
    return (1 << (MIN_MOD_LOG2 + i)) - 1;
  endfunction
endpackage

// File: rtl/pss_cfg.sv
module pss_cfg #(
  parameter int BW = 13,
  parameter int AW = 5,
  parameter int PSW = 2,
  parameter logic [BW-1:0] DEF_B = 13'd16,
  parameter logic [AW-1:0] DEF_A = 5'd0
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [BW-1:0] req_b,
  input  logic [AW-1:0] req_a,
  input  logic [PSW-1:0] req_psel,
  output logic [BW-1:0] sel_b,
  output logic [AW-1:0] sel_a,
  output logic          err
);
  import pss_pkg::*;

  localparam int NSEL = 1 << PSW;
  localparam logic [BW-1:0] B_MIN = BW'(B_LEGAL_MIN);

  logic [NSEL-1:0] a_fits;
  logic [BW-1:0]   act_b;
  logic [AW-1:0]   act_a;
  logic            req_ok;

  // One range comparator per selector code; unused codes are illegal.
  for (genvar i = 0; i < NSEL; i++) begin : g_lim
    if (i < NUM_MOD) begin : g_legal
      localparam logic [AW-1:0] LIM = AW'(swallow_limit(i));
      assign a_fits[i] = (req_a <= LIM);
    end else begin : g_illegal
      assign a_fits[i] = 1'b0;
    end
  end

  always_comb begin
    req_ok = a_fits[req_psel] && (req_b >= B_MIN) &&
             ({{(BW-AW){1'b0}}, req_a} <= req_b);
    sel_b  = req_ok ? req_b : act_b;
    sel_a  = req_ok ? req_a : act_a;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_b <= DEF_B;
      act_a <= DEF_A;
      err   <= 1'b0;
    end else if (load) begin
      if (req_ok) begin
        act_b <= req_b;
        act_a <= req_a;
      end else begin
        err <= 1'b1;
      end
    end
  end

  // R6: the setting kept in use always respects the B floor and A <= B.
  a_r6_held_legal: assert property (@(posedge clk) disable iff (!rst_n)
    (act_b >= B_MIN) && ({{(BW-AW){1'b0}}, act_a} <= act_b));
endmodule

// File: rtl/pss_main_cnt.sv
module pss_main_cnt #(
  parameter int BW = 13,
  parameter logic [BW-1:0] RST_VAL = 13'd16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [BW-1:0] load_val,
  output logic          tc
);
  localparam logic [BW-1:0] ONE = BW'(1);

  logic [BW-1:0] left;

  // Counts the clocks left in the period; reaching zero ends it.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    left <= RST_VAL - ONE;
    else if (load) left <= load_val - ONE;
    else           left <= left - ONE;
  end

  assign tc = (left == '0);
endmodule

// File: rtl/pss_swallow_cnt.sv
module pss_swallow_cnt #(
  parameter int AW = 5,
  parameter logic [AW-1:0] RST_VAL = 5'd0
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [AW-1:0] load_val,
  output logic          busy
);
  localparam logic [AW-1:0] ONE = AW'(1);

  logic [AW-1:0] left;

  // Counts down the P+1 cycles still owed; parks at zero.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)           left <= RST_VAL;
    else if (load)        left <= load_val;
    else if (left != '0)  left <= left - ONE;
  end

  assign busy = (left != '0);
endmodule

// File: rtl/pss_divider.sv
module pss_divider #(
  parameter int BW = 13,
  parameter int AW = 5,
  parameter int PSW = 2,
  parameter logic [BW-1:0] DEF_B = 13'd16,
  parameter logic [AW-1:0] DEF_A = 5'd0
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           hold,
  input  logic [BW-1:0]  cfg_b,
  input  logic [AW-1:0]  cfg_a,
  input  logic [PSW-1:0] cfg_psel,
  output logic           mod_ctl,
  output logic           div_out,
  output logic           cfg_err
);
  logic          tc;
  logic          busy;
  logic          reload;
  logic [BW-1:0] sel_b;
  logic [AW-1:0] sel_a;

  assign reload = hold | tc;

  pss_cfg #(.BW(BW), .AW(AW), .PSW(PSW), .DEF_B(DEF_B), .DEF_A(DEF_A)) u_cfg (
    .clk(clk), .rst_n(rst_n), .load(reload),
    .req_b(cfg_b), .req_a(cfg_a), .req_psel(cfg_psel),
    .sel_b(sel_b), .sel_a(sel_a), .err(cfg_err)
  );

  pss_main_cnt #(.BW(BW), .RST_VAL(DEF_B)) u_main (
    .clk(clk), .rst_n(rst_n), .load(reload), .load_val(sel_b), .tc(tc)
  );

  pss_swallow_cnt #(.AW(AW), .RST_VAL(DEF_A)) u_swallow (
    .clk(clk), .rst_n(rst_n), .load(reload), .load_val(sel_a), .busy(busy)
  );

  assign div_out = tc & ~hold;
  assign mod_ctl = busy & ~hold;

  // R2: the period pulse is a single clock wide (B is at least 3).
  a_r2_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    div_out |=> !div_out);

  // R3: once the swallow phase ends, P is kept until the period reloads.
  a_r3_mod_stays_low: assert property (@(posedge clk) disable iff (!rst_n)
    (!mod_ctl && !hold && !div_out) |=> !mod_ctl);

  // R7: after a held clock the counters restart, so no period ends next.
  a_r7_hold_restart: assert property (@(posedge clk) disable iff (!rst_n)
    hold |=> !div_out);

  // R9: the configuration error flag never clears by itself.
  a_r9_err_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_err |=> cfg_err);
endmodule

// File: tb/pss_divider_test.sv
module pss_divider_test;
  localparam int DB = 16;
  localparam int DA = 0;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        hold = 1'b0;
  logic [12:0] cfg_b = 13'(DB);
  logic [4:0]  cfg_a = 5'(DA);
  logic [1:0]  cfg_psel = 2'd0;
  logic        mod_ctl, div_out, cfg_err;

  always #10 clk = ~clk;

  pss_divider #(.DEF_B(13'(DB)), .DEF_A(5'(DA))) uut (
    .clk(clk), .rst_n(rst_n), .hold(hold), .cfg_b(cfg_b), .cfg_a(cfg_a),
    .cfg_psel(cfg_psel), .mod_ctl(mod_ctl), .div_out(div_out), .cfg_err(cfg_err)
  );

  int    vectors = 0;
  int    misses = 0;
  int    cycles = 0;
  bit    done = 0;
  string tag = "R1";

  // Behavioural model: accepted B/A, position within period, error flag.
  int m_b = DB, m_a = DA, m_pos = 0;
  bit m_err = 0;

  function automatic bit legal(int b, int a, int ps);
    int p;
    p = (ps == 0) ? 8 : (ps == 1) ? 16 : (ps == 2) ? 32 : 0;
    return (p != 0) && (b >= 3) && (a <= p - 1) && (a <= b);
  endfunction

  task automatic chk(string what, int act, int exp);
    vectors++;
    if (act != exp) begin
      misses++;
      $display("FAIL %s %s: got %0d expected %0d (t=%0t)", tag, what, act, exp, $time);
    end
  endtask

  always @(posedge clk) begin
    if (!rst_n) begin
      m_b = DB; m_a = DA; m_pos = 0; m_err = 0;
    end else if (hold || m_pos == m_b - 1) begin
      if (legal(int'(cfg_b), int'(cfg_a), int'(cfg_psel))) begin
        m_b = int'(cfg_b); m_a = int'(cfg_a);
      end else begin
        m_err = 1;
      end
      m_pos = 0;
    end else begin
      m_pos++;
    end
    #5;
    if (!done) begin
      chk("div_out", int'(div_out), int'(rst_n && !hold && m_pos == m_b - 1));
      chk("mod_ctl", int'(mod_ctl), int'(rst_n && !hold && m_pos < m_a));
      chk("cfg_err", int'(cfg_err), int'(m_err));
    end
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 20000 && !done) begin
      done = 1;
      misses++;
      $display("FAIL watchdog: got %0d cycles expected completion", cycles);
      $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
      $finish;
    end
  end

  task automatic run(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic set(int b, int a, int ps);
    cfg_b = 13'(b); cfg_a = 5'(a); cfg_psel = 2'(ps);
  endtask

  initial begin
    tag = "R1"; run(3);              // reset state
    rst_n = 1'b1;
    tag = "R2"; run(40);             // default period of 16
    tag = "R5"; set(10, 3, 0); run(4); set(7, 2, 0); run(50);  // only end-of-period sample counts
    tag = "R3"; set(20, 15, 1); run(80);
    tag = "R4"; set(40, 31, 2); run(130); set(12, 9, 1); run(50); set(9, 7, 0); run(30);
    tag = "R8"; set(5, 5, 1); run(30); set(6, 0, 2); run(30);
    tag = "R7"; run(3); hold = 1'b1; run(7); hold = 1'b0; run(30);
    hold = 1'b1; set(9, 4, 0); run(2); hold = 1'b0; run(40);
    tag = "R6"; set(2, 0, 0); run(20);  // B below floor
    set(4, 6, 2); run(20);              // A above B
    set(10, 1, 3); run(20);             // illegal selector
    set(30, 9, 0); run(40);             // A above P-1
    tag = "R9"; set(11, 2, 0); run(40); // still flagged, setting accepted
    rst_n = 1'b0; run(2); rst_n = 1'b1; run(30);
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
    $finish;
  end
endmodule